// File: doc/BRIEF.md
# Quadrature and Pulse Input Decoder

This block sits in front of a position counter. It takes two asynchronous count lines, brings them into the system clock domain through a shift-register synchroniser, and turns each sampled change into a one-cycle count-enable strobe with a direction bit. The counter that consumes the strobes is not part of the block.

A mode input picks the meaning of the two lines. In pulse mode one line carries up pulses and the other carries down pulses, and every rising edge counts once. In quadrature mode the lines are two channels a quarter period apart. A two-bit selector then picks one, two or four counts per full input cycle. A direction-invert input flips the sense of every count in both modes.

In quadrature mode, a sample in which both channels changed at once cannot come from a legal signal. Such a sample is treated as noise. It gives no count and sets a sticky error flag, which stays set until it is cleared through a dedicated input. Inputs must stay below a quarter of the clock rate in quadrature mode and below half of it in pulse mode.

Top module: `qdec_top`

## Requirements
- R1: While `rstN` is low and directly after reset, `cntEn`, `cntUp` and `errFlag` are low.
- R2: In quadrature mode (`pulseMode`=0) with `edgeSel` 2 or 3, every single-channel change counts once. The state order {inA,inB} 00→10→11→01→00 is clockwise and counts up (`cntUp`=1). The reverse order counts down.
- R3: In quadrature mode with `edgeSel`=1, only changes of `inA` (with `inB` steady) count, using the direction rule of R2. Changes of `inB` alone give no count.
- R4: In quadrature mode with `edgeSel`=0, only two transitions count: {inA,inB} 00→10 counts up, and 10→00 counts down. No other transition counts.
- R5: With `invertDir`=1, every count is reported in the opposite direction, in both modes.
- R6: In pulse mode (`pulseMode`=1), a sampled rising edge of `inA` counts up and a rising edge of `inB` counts down. Rising edges on both lines in the same sample give no count. Falling edges never count. `edgeSel` has no effect.
- R7: In quadrature mode, a sample in which both channels changed sets `errFlag` and produces no count. Pulse mode never sets `errFlag`.
- R8: `errFlag` stays set until `errClr` is sampled high, and it is then low from the next cycle. A new error in the same cycle as a clear leaves the flag set.
- R9: A count is reported on `cntEn` for exactly one cycle, three rising clock edges after the input change: two synchroniser stages and one output register.
- R10: `cntUp` is low in every cycle in which `cntEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| pulseMode | input | 1 | 1: up/down pulse lines, 0: quadrature channels |
| edgeSel | input | 2 | Quadrature evaluation: 0 x1, 1 x2, 2 or 3 x4 |
| invertDir | input | 1 | Reverses the reported direction |
| errClr | input | 1 | Clears the sticky error flag |
| inA | input | 1 | Up pulse line or channel A (asynchronous) |
| inB | input | 1 | Down pulse line or channel B (asynchronous) |
| cntEn | output | 1 | One-cycle count strobe |
| cntUp | output | 1 | Direction of the count, 1 = up |
| errFlag | output | 1 | Sticky abnormal-transition flag |

## Verification
Every result of the block lands three rising edges after the input edge that caused it: the strobe, its direction and the error flag alike. A clear takes effect one edge after it is sampled. The bench changes inputs on the falling edge, counts exactly three rising edges, and samples on the following falling edge. It then checks one cycle later that the strobe has dropped again. The sweep covers every pair of previous and next input states under every mode, edge selection and inversion setting. Before each step the inputs are allowed to settle and the flag is cleared, so each sample reflects a single transition.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    EDGE_X1  = 2'd0,
    EDGE_X2  = 2'd1,
    EDGE_X4  = 2'd2,
    EDGE_X4B = 2'd3
  } edgeSel_e;

  typedef struct packed {
    logic step;
    logic up;
    logic fault;
  } qdStrobe_t;

endpackage

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inA,
  input  logic      inB,
  input  logic      errClr,
  input  qdStrobe_t strobe,
  output logic [1:0] curAB,
  output logic [1:0] prevAB,
  output logic      cntEn,
  output logic      cntUp,
  output logic      errFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] shA;
  logic [SYNC_STAGES-1:0] shB;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shA[i] <= 1'b0;
          shB[i] <= 1'b0;
        end else if (i == 0) begin
          shA[i] <= inA;
          shB[i] <= inB;
        end else begin
          shA[i] <= shA[(i == 0) ? 0 : i - 1];
          shB[i] <= shB[(i == 0) ? 0 : i - 1];
        end
      end
    end
  endgenerate

  assign curAB = {shA[LAST], shB[LAST]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAB  <= 2'b00;
      cntEn   <= 1'b0;
      cntUp   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      prevAB <= curAB;
      cntEn  <= strobe.step;
      cntUp  <= strobe.step & strobe.up;
      if (strobe.fault)
        errFlag <= 1'b1;
      else if (errClr)
        errFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
(
  input  logic       pulseMode,
  input  logic [1:0] edgeSel,
  input  logic       invertDir,
  input  logic [1:0] curAB,
  input  logic [1:0] prevAB,
  output qdStrobe_t  strobe
);
  edgeSel_e  evalMode;
  logic      aChg;
  logic      bChg;
  logic      moved;
  logic      cw;
  logic      quadHit;
  logic      upRise;
  logic      dnRise;
  logic      hit;
  logic      dir;

  always_comb begin
    evalMode = edgeSel_e'(edgeSel);
    aChg     = curAB[1] ^ prevAB[1];
    bChg     = curAB[0] ^ prevAB[0];
    moved    = aChg ^ bChg;
    // clockwise: after an A change A differs from B, after a B change they match
    cw       = aChg ? (curAB[1] != curAB[0]) : (curAB[1] == curAB[0]);
    case (evalMode)
      EDGE_X1: quadHit = moved &
                         ((cw  && prevAB == 2'b00 && curAB == 2'b10) ||
                          (!cw && prevAB == 2'b10 && curAB == 2'b00));
      EDGE_X2: quadHit = aChg & ~bChg;
      default: quadHit = moved;
    endcase

    upRise = curAB[1] & ~prevAB[1];
    dnRise = curAB[0] & ~prevAB[0];

    if (pulseMode) begin
      hit          = upRise ^ dnRise;
      dir          = upRise;
      strobe.fault = 1'b0;
    end else begin
      hit          = quadHit;
      dir          = cw;
      strobe.fault = aChg & bChg;
    end
    strobe.step = hit;
    strobe.up   = hit & (dir ^ invertDir);
  end

endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pulseMode,
  input  logic [1:0] edgeSel,
  input  logic       invertDir,
  input  logic       errClr,
  input  logic       inA,
  input  logic       inB,
  output logic       cntEn,
  output logic       cntUp,
  output logic       errFlag
);
  qdStrobe_t  strobe;
  logic [1:0] curAB;
  logic [1:0] prevAB;

  qdec_ctrl u_ctrl (
    .pulseMode (pulseMode),
    .edgeSel   (edgeSel),
    .invertDir (invertDir),
    .curAB     (curAB),
    .prevAB    (prevAB),
    .strobe    (strobe)
  );

  qdec_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inA     (inA),
    .inB     (inB),
    .errClr  (errClr),
    .strobe  (strobe),
    .curAB   (curAB),
    .prevAB  (prevAB),
    .cntEn   (cntEn),
    .cntUp   (cntUp),
    .errFlag (errFlag)
  );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker (
  input logic clk,
  input logic rstN,
  input logic errClr,
  input logic cntEn,
  input logic cntUp,
  input logic errFlag
);

  // R10
  up_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |-> !cntUp);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  // R8
  err_fall_on_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFlag) |-> $past(errClr));

  // R7
  fault_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !cntEn);

endmodule

bind qdec_top qdec_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .errClr  (errClr),
  .cntEn   (cntEn),
  .cntUp   (cntUp),
  .errFlag (errFlag)
);

// File: tb/sim_qdec_top.sv
module sim_qdec_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseMode = 1'b0;
  logic [1:0] edgeSel = 2'd0;
  logic       invertDir = 1'b0;
  logic       errClr = 1'b0;
  logic       inA = 1'b0;
  logic       inB = 1'b0;
  logic       cntEn;
  logic       cntUp;
  logic       errFlag;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qdec_top u0 (
    .clk(clk), .rstN(rstN), .pulseMode(pulseMode), .edgeSel(edgeSel),
    .invertDir(invertDir), .errClr(errClr), .inA(inA), .inB(inB),
    .cntEn(cntEn), .cntUp(cntUp), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b pm=%0b sel=%0d inv=%0b",
               req, act, exp, pulseMode, edgeSel, invertDir);
    end
  endtask

  // position along the clockwise cycle 00,10,11,01
  function automatic int pos(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic settleAndClear(input logic [1:0] ab);
    @(negedge clk);
    inA = ab[1];
    inB = ab[0];
    repeat (5) @(posedge clk);
    @(negedge clk);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1
    chk("R1 cntEn in reset", cntEn, 1'b0);
    chk("R1 cntUp in reset", cntUp, 1'b0);
    chk("R1 errFlag in reset", errFlag, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cntEn after reset", cntEn, 1'b0);
    chk("R1 errFlag after reset", errFlag, 1'b0);

    for (int pm = 0; pm < 2; pm++)
      for (int inv = 0; inv < 2; inv++)
        for (int sel = 0; sel < 4; sel++)
          for (int p = 0; p < 4; p++)
            for (int n = 0; n < 4; n++) begin
              logic [1:0] pa = 2'(p);
              logic [1:0] na = 2'(n);
              logic expEn, expUp, expErr, dirUp;
              pulseMode = logic'(pm);
              invertDir = logic'(inv);
              edgeSel   = 2'(sel);
              settleAndClear(pa);
              chk("R8 cleared", errFlag, 1'b0);
              expEn = 1'b0; dirUp = 1'b0; expErr = 1'b0;
              if (pm == 1) begin
                // R6: rising edges only, coincident rises cancel
                logic ur, dr;
                ur = na[1] & ~pa[1];
                dr = na[0] & ~pa[0];
                expEn = ur ^ dr;
                dirUp = ur;
              end else begin
                int d;
                d = (pos(na) - pos(pa) + 4) % 4;
                if (d == 2) expErr = 1'b1;                 // R7
                else if (d != 0) begin
                  dirUp = (d == 1);
                  if (sel >= 2) expEn = 1'b1;              // R2
                  else if (sel == 1) expEn = (na[1] != pa[1]); // R3
                  else expEn = (d == 1 && pos(na) == 1) ||
                               (d == 3 && pos(na) == 0);   // R4
                end
              end
              expUp = expEn & (dirUp ^ logic'(inv));       // R5
              inA = na[1];
              inB = na[0];
              repeat (3) @(posedge clk);
              @(negedge clk);
              // R9 strobe due on the third edge
              chk(pm ? "R6 cntEn" : (sel == 0 ? "R4 cntEn" :
                  (sel == 1 ? "R3 cntEn" : "R2 cntEn")), cntEn, expEn);
              chk("R5 cntUp", cntUp, expUp);
              chk("R7 errFlag", errFlag, expErr);
              @(negedge clk);
              chk("R9 strobe one cycle", cntEn, 1'b0);
              chk("R10 cntUp idle", cntUp, 1'b0);
              chk("R8 sticky", errFlag, expErr);
            end

    // R8: error held over many cycles, and set wins over a simultaneous clear
    pulseMode = 1'b0;
    edgeSel   = 2'd2;
    invertDir = 1'b0;
    settleAndClear(2'b00);
    inA = 1'b1; inB = 1'b1;
    repeat (3) @(posedge clk);
    repeat (20) @(negedge clk);
    chk("R8 sticky long", errFlag, 1'b1);
    settleAndClear(2'b00);
    chk("R8 cleared before race", errFlag, 1'b0);
    inA = 1'b1; inB = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    chk("R8 set wins over clear", errFlag, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule